// File: doc/BRIEF.md
# Quadrature Decoder with Multiplier

This block sits in front of an up/down counter. It turns two encoder phase inputs and an index input into three single-cycle controls for that counter: a count-enable pulse, a direction level that qualifies the pulse, and an index pulse. The counter, any capture of its value and any register access are outside the block. All configuration arrives on static select inputs.

The count pulse can come from several sources. The encoder phases can be decoded at one, two or four counts per phase cycle. A step/direction mode makes the index line the step and phase A the direction. A digital input edge can be counted. The system clock can count up or down, gated by a software bit. The index pulse can come from the encoder index line, from a digital input, or from a software bit, or it can be switched off. Every external signal passes through a synchroniser before it is decoded. If both phases change in the same sample, no count is made and a sticky error flag is raised.

Top module: `quad_count_front`

## Requirements
- R1: While reset is high and in the cycle after it falls, with all inputs low and index_sel = 11, cnt_en, cnt_up, idx_pulse and quad_err are all 0.
- R2: With count_sel = 00 and mult_sel = 00 (x4), each change of exactly one phase gives one cnt_en pulse. With the phase state written {A,B}, the order 00,10,11,01 (A leading) counts with cnt_up = 1 and the reverse order counts with cnt_up = 0.
- R3: With mult_sel = 01 (x2), only changes of phase A count, which gives two counts per phase cycle, with direction as in R2.
- R4: With mult_sel = 10 (x1), a count is made only when phase A changes while phase B is low: A rising counts up and A falling counts down. Dithering across that edge therefore alternates up and down.
- R5: A sample in which both phases change gives no count and sets quad_err. quad_err stays set until reset.
- R6: With mult_sel = 11 (step/direction), each rising edge of the index input gives one count, and cnt_up equals the level of phase A. Falling edges of the index input do not count.
- R7: With count_sel = 01, the digital count input is counted with cnt_up = 1. It counts its rising edge when src_edge = 0 and its falling edge when src_edge = 1.
- R8: With count_sel = 10 the block counts up on every clock, and with count_sel = 11 it counts down on every clock, but only while src_edge = 1. With src_edge = 0 it makes no count.
- R9: With index_sel = 00 (encoder index) or 01 (digital index), idx_pulse lasts one cycle. It fires on the rising edge of the chosen line when idx_edge = 0 and on its falling edge when idx_edge = 1.
- R10: With index_sel = 10, idx_edge acts as a software index: a change from 0 to 1 gives one idx_pulse. With index_sel = 11 no idx_pulse is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| enc_index | input | 1 | Encoder index / step input (asynchronous) |
| dig_count | input | 1 | Digital input used as count source |
| dig_index | input | 1 | Digital input used as index source |
| mult_sel | input | 2 | 00 x4, 01 x2, 10 x1, 11 step/direction |
| count_sel | input | 2 | 00 encoder, 01 digital, 10 clock up, 11 clock down |
| src_edge | input | 1 | Digital edge select, or clock-mode gate |
| index_sel | input | 2 | 00 encoder, 01 digital, 10 software, 11 off |
| idx_edge | input | 1 | Index polarity, or software index level |
| cnt_en | output | 1 | One count this cycle |
| cnt_up | output | 1 | Direction of the count (1 = up) |
| idx_pulse | output | 1 | Index event this cycle |
| quad_err | output | 1 | Sticky illegal-transition flag |

## Verification
The assertions check, on every cycle, the clock-source gating and direction, the absence of index pulses when the index is switched off, the suppression of counts on illegal phase changes, and the stickiness of the error flag. The bench sweeps every quadrature step in both directions for the x4, x2 and x1 modes and compares the number and direction of the resulting pulses with counts computed from the phase changes. Those sweeps, together with the step/direction, digital-edge and index-polarity scenarios, show the multiplier ratios and edge choices, which no single-cycle property captures.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {MUL_X4 = 2'b00, MUL_X2 = 2'b01, MUL_X1 = 2'b10, MUL_STEP = 2'b11} mul_t;
  typedef enum logic [1:0] {SRC_ENC = 2'b00, SRC_DIG = 2'b01, SRC_CLKUP = 2'b10, SRC_CLKDN = 2'b11} src_t;
  typedef enum logic [1:0] {IDX_ENC = 2'b00, IDX_DIG = 2'b01, IDX_SW = 2'b10, IDX_OFF = 2'b11} idx_t;
  localparam int unsigned NUM_ASYNC = 5;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qd_quad.sv
module qd_quad
  import qd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic       step,
  input  logic [1:0] mult,
  output logic       ev,
  output logic       up,
  output logic       bad
);
  logic pa, pb, pstep;
  logic da, db, one_change;

  always_ff @(posedge clk) begin
    if (rst) {pa, pb, pstep} <= 3'b000;
    else     {pa, pb, pstep} <= {a, b, step};
  end

  assign da         = a ^ pa;
  assign db         = b ^ pb;
  assign bad        = da & db;
  assign one_change = da ^ db;

  always_comb begin
    ev = 1'b0;
    up = a ^ pb;
    unique case (mul_t'(mult))
      MUL_X4:   ev = one_change;
      MUL_X2:   ev = one_change & da;
      MUL_X1:   ev = one_change & da & ~b;
      MUL_STEP: begin
        ev = step & ~pstep;
        up = a;
      end
      default:  ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/qd_index.sv
module qd_index
  import qd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enc_idx,
  input  logic       dig_idx,
  input  logic [1:0] sel,
  input  logic       edge_bit,
  output logic       pulse
);
  logic active, active_q;

  always_comb begin
    unique case (idx_t'(sel))
      IDX_ENC: active = enc_idx ^ edge_bit;
      IDX_DIG: active = dig_idx ^ edge_bit;
      IDX_SW:  active = edge_bit;
      default: active = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      active_q <= active;
      pulse    <= active & ~active_q;
    end
  end

  p_off_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == IDX_OFF) |=> !pulse);
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (pulse && $stable(sel) && $stable(edge_bit)) |=> !pulse);
endmodule

// File: rtl/quad_count_front.sv
module quad_count_front
  import qd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       enc_index,
  input  logic       dig_count,
  input  logic       dig_index,
  input  logic [1:0] mult_sel,
  input  logic [1:0] count_sel,
  input  logic       src_edge,
  input  logic [1:0] index_sel,
  input  logic       idx_edge,
  output logic       cnt_en,
  output logic       cnt_up,
  output logic       idx_pulse,
  output logic       quad_err
);
  logic [NUM_ASYNC-1:0] raw, syn;
  logic s_a, s_b, s_idx, s_dcnt, s_didx;
  logic q_ev, q_up, q_bad;
  logic dcnt_q, dig_ev;
  logic nxt_en, nxt_up;

  assign raw = {dig_index, dig_count, enc_index, phase_b, phase_a};

  qd_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign {s_didx, s_dcnt, s_idx, s_b, s_a} = syn;

  qd_quad u_quad (
    .clk(clk), .rst(rst), .a(s_a), .b(s_b), .step(s_idx),
    .mult(mult_sel), .ev(q_ev), .up(q_up), .bad(q_bad)
  );

  qd_index u_index (
    .clk(clk), .rst(rst), .enc_idx(s_idx), .dig_idx(s_didx),
    .sel(index_sel), .edge_bit(idx_edge), .pulse(idx_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) dcnt_q <= 1'b0;
    else     dcnt_q <= s_dcnt;
  end

  assign dig_ev = src_edge ? (dcnt_q & ~s_dcnt) : (s_dcnt & ~dcnt_q);

  always_comb begin
    unique case (src_t'(count_sel))
      SRC_ENC:   begin nxt_en = q_ev;     nxt_up = q_up; end
      SRC_DIG:   begin nxt_en = dig_ev;   nxt_up = 1'b1; end
      SRC_CLKUP: begin nxt_en = src_edge; nxt_up = 1'b1; end
      default:   begin nxt_en = src_edge; nxt_up = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en   <= 1'b0;
      cnt_up   <= 1'b0;
      quad_err <= 1'b0;
    end else begin
      cnt_en <= nxt_en;
      if (nxt_en) cnt_up <= nxt_up;
      if (q_bad)  quad_err <= 1'b1;
    end
  end

  p_clk_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (count_sel[1] && !src_edge) |=> !cnt_en);
  p_clk_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (count_sel[1] && src_edge) |=> (cnt_en && (cnt_up == !$past(count_sel[0]))));
  p_illegal_nocount_r5: assert property (@(posedge clk) disable iff (rst)
    (count_sel == SRC_ENC && mult_sel != MUL_STEP && q_bad) |=> !cnt_en);
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    quad_err |=> quad_err);
  p_err_set_r5: assert property (@(posedge clk) disable iff (rst)
    q_bad |=> quad_err);
endmodule

// File: tb/tb_quad_count_front.sv
module tb_quad_count_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_a = 0, phase_b = 0, enc_index = 0, dig_count = 0, dig_index = 0;
  logic [1:0] mult_sel = 2'b00, count_sel = 2'b00, index_sel = 2'b11;
  logic src_edge = 0, idx_edge = 0;
  logic cnt_en, cnt_up, idx_pulse, quad_err;

  int n_tests = 0, n_fail = 0;
  int w_cnt, w_up, w_dn, w_idx;

  always #2.5 clk = ~clk;

  quad_count_front dut (
    .clk(clk), .rst(rst), .phase_a(phase_a), .phase_b(phase_b),
    .enc_index(enc_index), .dig_count(dig_count), .dig_index(dig_index),
    .mult_sel(mult_sel), .count_sel(count_sel), .src_edge(src_edge),
    .index_sel(index_sel), .idx_edge(idx_edge),
    .cnt_en(cnt_en), .cnt_up(cnt_up), .idx_pulse(idx_pulse), .quad_err(quad_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // observe a window of cycles after the inputs were changed
  task automatic window();
    w_cnt = 0; w_up = 0; w_dn = 0; w_idx = 0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      if (cnt_en) begin
        w_cnt++;
        if (cnt_up) w_up++; else w_dn++;
      end
      if (idx_pulse) w_idx++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] gray [4];
    gray[0] = 2'b00; gray[1] = 2'b10; gray[2] = 2'b11; gray[3] = 2'b01;

    repeat (2) @(posedge clk); #1;
    check("R1 cnt_en in reset", cnt_en, 0);
    check("R1 idx_pulse in reset", idx_pulse, 0);
    do_reset();
    @(posedge clk); #1;
    check("R1 cnt_en after reset", cnt_en, 0);
    check("R1 cnt_up after reset", cnt_up, 0);
    check("R1 quad_err after reset", quad_err, 0);

    // R2 R3 R4: sweep all steps both directions for x4, x2, x1
    for (int m = 0; m < 3; m++) begin
      for (int d = 0; d < 2; d++) begin
        int pos, nxt, exp_n, cur_a, new_a, new_b;
        mult_sel = 2'(m);
        pos = 0;
        {phase_a, phase_b} = gray[0];
        window();
        for (int s = 0; s < 8; s++) begin
          nxt   = d ? (pos + 3) % 4 : (pos + 1) % 4;
          cur_a = gray[pos][1];
          new_a = gray[nxt][1];
          new_b = gray[nxt][0];
          if (m == 0)      exp_n = 1;
          else if (m == 1) exp_n = (cur_a != new_a) ? 1 : 0;
          else             exp_n = (cur_a != new_a && new_b == 0) ? 1 : 0;
          {phase_a, phase_b} = gray[nxt];
          window();
          case (m)
            0: check("R2 x4 count", w_cnt, exp_n);
            1: check("R3 x2 count", w_cnt, exp_n);
            default: check("R4 x1 count", w_cnt, exp_n);
          endcase
          if (exp_n == 1) check("R2 direction", w_up, d ? 0 : 1);
          pos = nxt;
        end
      end
    end

    // R4 dither across the counting edge in x1
    mult_sel = 2'b10; {phase_a, phase_b} = 2'b00; window();
    for (int k = 0; k < 3; k++) begin
      phase_a = 1; window();
      check("R4 dither up", w_up, 1);
      phase_a = 0; window();
      check("R4 dither down", w_dn, 1);
    end
    check("R5 no error on legal steps", quad_err, 0);

    // R5 illegal transitions
    mult_sel = 2'b00;
    {phase_a, phase_b} = 2'b11; window();
    check("R5 illegal no count", w_cnt, 0);
    check("R5 error set", quad_err, 1);
    phase_b = 0; window();
    check("R5 legal step after error counts", w_cnt, 1);
    check("R5 error sticky", quad_err, 1);
    do_reset(); #1;
    check("R5 error cleared by reset", quad_err, 0);
    {phase_a, phase_b} = 2'b00; window();

    // R6 step/direction
    mult_sel = 2'b11;
    phase_a = 1; window();
    enc_index = 1; window();
    check("R6 step up count", w_up, 1);
    enc_index = 0; window();
    check("R6 falling step ignored", w_cnt, 0);
    phase_a = 0; window();
    enc_index = 1; window();
    check("R6 step down count", w_dn, 1);
    enc_index = 0; window();

    // R7 digital source
    count_sel = 2'b01; src_edge = 0; window();
    dig_count = 1; window();
    check("R7 rising counts", w_up, 1);
    dig_count = 0; window();
    check("R7 falling ignored", w_cnt, 0);
    src_edge = 1; window();
    dig_count = 1; window();
    check("R7 rising ignored edge1", w_cnt, 0);
    dig_count = 0; window();
    check("R7 falling counts edge1", w_up, 1);

    // R8 clock sources
    count_sel = 2'b10; src_edge = 1; window();
    check("R8 clock up every cycle", w_up, 6);
    count_sel = 2'b11; window();
    check("R8 clock down every cycle", w_dn, 6);
    src_edge = 0; window();
    check("R8 gate off", w_cnt, 0);
    count_sel = 2'b10; window();
    check("R8 gate off up", w_cnt, 0);
    count_sel = 2'b01; window();

    // R9 hardware index sources
    for (int src = 0; src < 2; src++) begin
      index_sel = 2'(src);
      for (int e = 0; e < 2; e++) begin
        idx_edge = e[0]; enc_index = 0; dig_index = 0; window();
        if (src == 0) enc_index = 1; else dig_index = 1;
        window();
        check("R9 index rise", w_idx, e ? 0 : 1);
        if (src == 0) enc_index = 0; else dig_index = 0;
        window();
        check("R9 index fall", w_idx, e ? 1 : 0);
      end
    end

    // R10 software index and index off
    index_sel = 2'b10; idx_edge = 0; window();
    idx_edge = 1; window();
    check("R10 software index pulse", w_idx, 1);
    idx_edge = 0; window();
    check("R10 software release silent", w_idx, 0);
    index_sel = 2'b11; window();
    enc_index = 1; dig_index = 1; idx_edge = 1; window();
    check("R10 index off", w_idx, 0);
    enc_index = 0; dig_index = 0; idx_edge = 0; window();
    check("R10 index off fall", w_idx, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule